// File: doc/BRIEF.md
# Dual-Processor Semaphore and Mailbox Unit

This unit sits on a simple single-cycle register bus and gives a main CPU and a coprocessor two ways to coordinate. The first is a word of semaphore bits. Software reads the word directly but can change it only through two write-only strobe registers: one sets bits and one clears them. The second is a pair of one-word mailboxes, one for each direction. The inbox carries messages from the coprocessor to the CPU. The outbox carries messages from the CPU to the coprocessor.

Each mailbox is a two-state machine, MB_EMPTY and MB_FULL, and the valid tag reads 1 in MB_FULL. It has three transitions. SEND is a write by the sending processor: it moves MB_EMPTY or MB_FULL to MB_FULL and stores the new word. A SEND in MB_FULL is an overwrite. TAKE is a read by the receiving processor: it moves MB_FULL to MB_EMPTY. Every other access leaves the state where it is. A requester input marks each access as coming from the CPU (0) or the coprocessor (1).

There are two interrupt outputs, one for each processor. Each is a flop that collects the mailbox conditions aimed at its processor. A full condition goes to the receiver of a mailbox, and an empty condition goes to its sender.

Top module: `dualcore_msg_sema`

## Requirements
- R1: After reset, every readable offset returns 0 and both interrupt outputs are 0.
- R2: Offset 0x0 returns the semaphore word, zero-extended to 32 bits. Writes to 0x0 leave the word unchanged.
- R3: A write to offset 0x4 sets each semaphore bit whose written bit is 1 and keeps every other bit. Reads of 0x4 return 0.
- R4: A write to offset 0x8 clears each semaphore bit whose written bit is 1 and keeps every other bit. Reads of 0x8 return 0.
- R5: The inbox (0x10) and the outbox (0x20) share one word layout. Bit 31 is the full-interrupt enable, bit 30 the empty-interrupt enable, bit 29 the valid tag, bit 28 always reads 0, and bits 27:0 hold the message (status 27:24, command 23:17, data 16:0). A SEND stores bits 31, 30 and 27:0 of the written word.
- R6: A SEND always sets the tag to 1, whatever value is written in bit 29. The inbox sender is the coprocessor (requester 1). The outbox sender is the CPU (requester 0).
- R7: A TAKE returns the mailbox word with the tag still 1 and sets the tag to 0 at that clock edge. A read by the sender returns the word and leaves the tag unchanged.
- R8: A write by a mailbox's receiving processor changes no bit of that mailbox.
- R9: The CPU interrupt equals (inbox full enable AND inbox tag) OR (outbox empty enable AND NOT outbox tag), registered. It shows a change one clock after the edge that changed the tag or the enable.
- R10: The coprocessor interrupt equals (outbox full enable AND outbox tag) OR (inbox empty enable AND NOT inbox tag), registered. It has the same one-clock lag as R9.
- R11: Every other offset reads as 0 and ignores writes. This includes 0xC, 0x14, 0x18, 0x1C and any address above 0x20. The address is compared over its full width, so no address aliases a mapped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_re | input | 1 | Read strobe for this cycle |
| bus_from_cop | input | 1 | Requester: 0 CPU, 1 coprocessor |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq_cpu | output | 1 | Level interrupt to the CPU |
| irq_cop | output | 1 | Level interrupt to the coprocessor |

## Verification
The bench builds the unit with ADDR_W = 8 and SEMA_W = 32. The wider address reaches offsets 0x40 and above, so the bench can show that an address above the map does not fold back onto the semaphore word or a mailbox. The full 32-bit semaphore word lets the bench use mask patterns that cover every bit position. The bench drives both mailboxes through SEND, overwrite and TAKE from each requester. It checks the one-clock lag of each interrupt on both the rising and the falling side of the tag.

// File: rtl/dms_pkg.sv
package dms_pkg;
    localparam int BUS_W        = 32;
    localparam int MB_FULL_BIT  = 31;
    localparam int MB_EMPTY_BIT = 30;
    localparam int MB_TAG_BIT   = 29;
    localparam int MB_MSG_W     = 28;

    localparam int OFS_SEMA_STAT = 'h00;
    localparam int OFS_SEMA_SET  = 'h04;
    localparam int OFS_SEMA_CLR  = 'h08;
    localparam int OFS_INBOX     = 'h10;
    localparam int OFS_OUTBOX    = 'h20;

    typedef enum logic {
        MB_EMPTY = 1'b0,
        MB_FULL  = 1'b1
    } mb_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_SET,
        SEL_CLR,
        SEL_INBOX,
        SEL_OUTBOX
    } reg_sel_e;
endpackage

// File: rtl/dms_addr_decode.sv
module dms_addr_decode
    import dms_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if (addr == ADDR_W'(OFS_SEMA_STAT))     sel = SEL_STAT;
        else if (addr == ADDR_W'(OFS_SEMA_SET)) sel = SEL_SET;
        else if (addr == ADDR_W'(OFS_SEMA_CLR)) sel = SEL_CLR;
        else if (addr == ADDR_W'(OFS_INBOX))    sel = SEL_INBOX;
        else if (addr == ADDR_W'(OFS_OUTBOX))   sel = SEL_OUTBOX;
        else                                    sel = SEL_NONE;
    end
endmodule

// File: rtl/dms_sema_bank.sv
module dms_sema_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] bits
);
    logic [WIDTH-1:0] sema_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      sema_q[b] <= 1'b0;
            else if (set_stb && mask[b])     sema_q[b] <= 1'b1;
            else if (clr_stb && mask[b])     sema_q[b] <= 1'b0;
        end
    end

    assign bits = sema_q;

    AST_SEMA_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((bits & $past(mask)) == $past(mask))) else $error("set lost"); // R3
    AST_SEMA_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> ((bits & $past(mask)) == '0)) else $error("clear lost"); // R4
    AST_SEMA_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_stb && !set_stb) |=> $stable(bits)) else $error("sema drift"); // R2
endmodule

// File: rtl/dms_mailbox.sv
module dms_mailbox
    import dms_pkg::*;
#(
    parameter bit SENDER_COP = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic                from_cop,
    input  logic                wr_full_en,
    input  logic                wr_empty_en,
    input  logic [MB_MSG_W-1:0] wr_msg,
    output logic [BUS_W-1:0]    word,
    output logic                full_en,
    output logic                empty_en,
    output logic                tag
);
    mb_state_e           state_q, state_d;
    logic                is_sender;
    logic                send, take;
    logic                full_en_q, empty_en_q;
    logic [MB_MSG_W-1:0] msg_q;

    assign is_sender = (from_cop == SENDER_COP);
    assign send      = hit && bus_we && is_sender;
    assign take      = hit && bus_re && !is_sender;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_EMPTY: if (send)      state_d = MB_FULL;
            MB_FULL: begin
                if (send)            state_d = MB_FULL;
                else if (take)       state_d = MB_EMPTY;
            end
            default:                 state_d = MB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_en_q  <= 1'b0;
            empty_en_q <= 1'b0;
            msg_q      <= '0;
        end else if (send) begin
            full_en_q  <= wr_full_en;
            empty_en_q <= wr_empty_en;
            msg_q      <= wr_msg;
        end
    end

    assign tag      = (state_q == MB_FULL);
    assign full_en  = full_en_q;
    assign empty_en = empty_en_q;
    assign word     = {full_en_q, empty_en_q, tag, 1'b0, msg_q};

    AST_SEND_SETS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        send |=> tag) else $error("send without tag"); // R6
    AST_TAKE_CLEARS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !tag) else $error("take kept tag"); // R7
    AST_SENDER_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_re && is_sender && !bus_we) |=> $stable(tag)) else $error("sender read moved tag"); // R7
    AST_RCV_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_we && !is_sender) |=> ($stable(msg_q) && $stable(full_en_q) && $stable(empty_en_q)))
        else $error("receiver write landed"); // R8
endmodule

// File: rtl/dms_irq_merge.sv
module dms_irq_merge #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cpu_cond,
    input  logic [NUM_SRC-1:0] cop_cond,
    output logic               irq_cpu,
    output logic               irq_cop
);
    logic cpu_q, cop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_q <= 1'b0;
            cop_q <= 1'b0;
        end else begin
            cpu_q <= |cpu_cond;
            cop_q <= |cop_cond;
        end
    end

    assign irq_cpu = cpu_q;
    assign irq_cop = cop_q;
endmodule

// File: rtl/dualcore_msg_sema.sv
module dualcore_msg_sema
    import dms_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SEMA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic              bus_from_cop,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_cpu,
    output logic              irq_cop
);
    localparam int              NUM_MB        = 2;
    localparam bit [NUM_MB-1:0] MB_SENDER_COP = 2'b01;

    reg_sel_e                      sel;
    logic [SEMA_W-1:0]             sema_bits;
    logic [NUM_MB-1:0]             mb_hit, mb_full_en, mb_empty_en, mb_tag;
    logic [NUM_MB-1:0][BUS_W-1:0]  mb_word;
    logic [NUM_MB-1:0]             cpu_cond, cop_cond;
    logic                          unused_wbits;

    assign unused_wbits = ^bus_wdata[MB_TAG_BIT -: 2];

    dms_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    dms_sema_bank #(.WIDTH(SEMA_W)) u_sema (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (bus_we && (sel == SEL_SET)),
        .clr_stb (bus_we && (sel == SEL_CLR)),
        .mask    (bus_wdata[SEMA_W-1:0]),
        .bits    (sema_bits)
    );

    assign mb_hit[0] = (sel == SEL_INBOX);
    assign mb_hit[1] = (sel == SEL_OUTBOX);

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        dms_mailbox #(.SENDER_COP(MB_SENDER_COP[g])) u_mb (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit         (mb_hit[g]),
            .bus_we      (bus_we),
            .bus_re      (bus_re),
            .from_cop    (bus_from_cop),
            .wr_full_en  (bus_wdata[MB_FULL_BIT]),
            .wr_empty_en (bus_wdata[MB_EMPTY_BIT]),
            .wr_msg      (bus_wdata[MB_MSG_W-1:0]),
            .word        (mb_word[g]),
            .full_en     (mb_full_en[g]),
            .empty_en    (mb_empty_en[g]),
            .tag         (mb_tag[g])
        );
        if (MB_SENDER_COP[g]) begin : g_to_cpu
            assign cpu_cond[g] = mb_full_en[g] & mb_tag[g];
            assign cop_cond[g] = mb_empty_en[g] & ~mb_tag[g];
        end else begin : g_to_cop
            assign cop_cond[g] = mb_full_en[g] & mb_tag[g];
            assign cpu_cond[g] = mb_empty_en[g] & ~mb_tag[g];
        end
    end

    dms_irq_merge #(.NUM_SRC(NUM_MB)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_cond (cpu_cond),
        .cop_cond (cop_cond),
        .irq_cpu  (irq_cpu),
        .irq_cop  (irq_cop)
    );

    always_comb begin
        unique case (sel)
            SEL_STAT:   bus_rdata = BUS_W'(sema_bits);
            SEL_INBOX:  bus_rdata = mb_word[0];
            SEL_OUTBOX: bus_rdata = mb_word[1];
            default:    bus_rdata = '0;
        endcase
    end

    AST_CPU_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mb_full_en[0] && !mb_empty_en[1]) |=> !irq_cpu) else $error("cpu irq unenabled"); // R9
    AST_COP_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mb_full_en[1] && !mb_empty_en[0]) |=> !irq_cop) else $error("cop irq unenabled"); // R10
    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE || sel == SEL_SET || sel == SEL_CLR) |-> (bus_rdata == '0))
        else $error("reserved read nonzero"); // R11
endmodule

// File: tb/sim_dualcore_msg_sema.sv
module sim_dualcore_msg_sema;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0, bus_re = 1'b0, bus_from_cop = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_cpu, irq_cop;
    int            n_cmp = 0, n_bad = 0;

    localparam logic CPU = 1'b0, COP = 1'b1;

    always #2 clk = ~clk;

    dualcore_msg_sema #(.ADDR_W(AW), .SEMA_W(32)) u0 (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_re, .bus_from_cop,
        .bus_wdata, .bus_rdata, .irq_cpu, .irq_cop
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input logic we, input logic re,
                          input logic src, input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_re = re; bus_from_cop = src; bus_wdata = wd;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1 bus_we = 1'b0; bus_re = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic src, input logic [31:0] wd);
        logic [31:0] dummy;
        access(a, 1'b1, 1'b0, src, wd, dummy);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic src, output logic [31:0] d);
        access(a, 1'b0, 1'b1, src, 32'h0, d);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_cpu", {31'h0, irq_cpu}, 32'h0);
        chk("R1 irq_cop", {31'h0, irq_cop}, 32'h0);
        rd(8'h00, CPU, d); chk("R1 sema", d, 32'h0);
        rd(8'h10, COP, d); chk("R1 inbox", d, 32'h0);
        rd(8'h20, CPU, d); chk("R1 outbox", d, 32'h0);
    endtask

    task automatic t_sema();
        logic [31:0] d;
        wr(8'h04, CPU, 32'hA5A5_0F0F);
        rd(8'h00, CPU, d); chk("R3 first set", d, 32'hA5A5_0F0F);
        wr(8'h04, COP, 32'h00F0_0000);
        rd(8'h00, COP, d); chk("R3 set keeps others", d, 32'hA5F5_0F0F);
        wr(8'h08, CPU, 32'h0000_0F00);
        rd(8'h00, CPU, d); chk("R4 clear", d, 32'hA5F5_000F);
        rd(8'h04, CPU, d); chk("R3 set reg reads 0", d, 32'h0);
        rd(8'h08, CPU, d); chk("R4 clr reg reads 0", d, 32'h0);
        wr(8'h00, CPU, 32'hFFFF_FFFF);
        rd(8'h00, CPU, d); chk("R2 status write ignored", d, 32'hA5F5_000F);
    endtask

    task automatic t_inbox();
        logic [31:0] d;
        wr(8'h10, COP, 32'hD5A3_C3F1);
        chk("R9 lag before", {31'h0, irq_cpu}, 32'h0);
        step();
        chk("R9 full irq", {31'h0, irq_cpu}, 32'h1);
        chk("R10 no empty irq", {31'h0, irq_cop}, 32'h0);
        rd(8'h10, COP, d); chk("R5 R6 layout", d, 32'hE5A3_C3F1);
        wr(8'h10, CPU, 32'h0000_1234);
        rd(8'h10, COP, d); chk("R8 receiver write", d, 32'hE5A3_C3F1);
        chk("R7 sender read keeps irq", {31'h0, irq_cpu}, 32'h1);
        rd(8'h10, CPU, d); chk("R7 take returns tag", d, 32'hE5A3_C3F1);
        chk("R9 lag after take", {31'h0, irq_cpu}, 32'h1);
        step();
        chk("R9 irq drops", {31'h0, irq_cpu}, 32'h0);
        chk("R10 empty irq", {31'h0, irq_cop}, 32'h1);
        rd(8'h10, CPU, d); chk("R7 tag cleared", d, 32'hC5A3_C3F1);
        wr(8'h10, COP, 32'h0000_0000);
        rd(8'h10, CPU, d); chk("R6 tag on zero word", d, 32'h2000_0000);
        step();
        chk("R10 enables off", {31'h0, irq_cop}, 32'h0);
        chk("R9 enables off", {31'h0, irq_cpu}, 32'h0);
    endtask

    task automatic t_outbox();
        logic [31:0] d;
        wr(8'h20, CPU, 32'h8000_0077);
        step();
        chk("R10 outbox full", {31'h0, irq_cop}, 32'h1);
        chk("R9 quiet", {31'h0, irq_cpu}, 32'h0);
        rd(8'h20, CPU, d); chk("R7 sender read", d, 32'hA000_0077);
        rd(8'h20, COP, d); chk("R7 take", d, 32'hA000_0077);
        step();
        chk("R10 drops", {31'h0, irq_cop}, 32'h0);
        wr(8'h20, COP, 32'hFFFF_FFFF);
        rd(8'h20, CPU, d); chk("R8 coprocessor write", d, 32'h8000_0077);
        wr(8'h20, CPU, 32'h4000_0001);
        step();
        chk("R9 empty en but full", {31'h0, irq_cpu}, 32'h0);
        rd(8'h20, COP, d);
        chk("R9 lag", {31'h0, irq_cpu}, 32'h0);
        step();
        chk("R9 outbox empty irq", {31'h0, irq_cpu}, 32'h1);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        logic [AW-1:0] rsv [5] = '{8'h0C, 8'h14, 8'h18, 8'h1C, 8'h40};
        for (int i = 0; i < 5; i++) begin
            wr(rsv[i], CPU, 32'hFFFF_FFFF);
            wr(rsv[i], COP, 32'hFFFF_FFFF);
            rd(rsv[i], CPU, d); chk("R11 reserved reads 0", d, 32'h0);
        end
        rd(8'h00, CPU, d); chk("R11 sema untouched", d, 32'hA5F5_000F);
        rd(8'h20, CPU, d); chk("R11 outbox untouched", d, 32'h4000_0001);
        wr(8'h08, CPU, 32'hFFFF_FFFF);
        rd(8'h00, CPU, d); chk("R4 clear all", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_sema();
        t_inbox();
        t_outbox();
        t_reserved();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule